// File: doc/BRIEF.md
# Configuration Address/Data Access Port

This block lets a host reach configuration registers through two 32-bit registers. The first is an address register. Software loads it with an enable bit, a bus number, a device number, a function number and a dword register index. The second is a data window. Reads and writes to the window are steered, using the current address register contents, either to a small register file inside the block or to one of `N_PORTS` downstream configuration ports. The block's own register file describes a host bridge.

The host side is a simple register bus. Each request carries a byte offset, a size code and write data in the low lanes. A read answers one cycle later. Only one bus is served. Device 0 is the block itself, and devices 1 to `N_PORTS` are the downstream ports in order. The function number takes no part in routing. Any access the block cannot serve reads back as all ones and has no effect when written.

Each downstream port sees the same register index, lane-aligned write data and byte enables. It also gets its own select line, and a write strobe qualifies the select. The port merges a write into its register using the byte enables. It returns its read data combinationally while it is selected.

Top module: `cfgp_access_port`

## Requirements
- R1: Out of reset the address register holds 0, so an address-register read returns 0 and a data-window read returns 0xFFFFFFFF. No response is pending (`rsp_valid` = 0) and no port is selected.
- R2: The address register fields are decoded as follows: enable at bit 31, bus at bits 23:16, device at bits 15:11, function at bits 10:8, register index at bits 7:2. `dev_idx` always carries bits 7:2.
- R3: Bus offsets 0 to 3 reach the address register. A write of 1, 2 or 4 bytes changes only the addressed bytes, and the other bytes keep their value.
- R4: A data-window access (bus offsets 4 to 7) is served as follows when the enable bit is clear or the bus field is nonzero: a read returns 0xFFFFFFFF and a write is dropped.
- R5: Device 0 selects the internal register file. Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads 0x06000000, which is bridge class 0x06 in bits 31:24 and host-bridge subclass 0x00 in bits 23:16. Dword 3 reads 0x00010000, which is bridge header type 0x01 in bits 23:16. Dwords 4 to 4+SCRATCH_DW-1 are writable with byte merging. Every other dword reads 0 and ignores writes. A write here never raises `dev_wr`.
- R6: Device k with 1 ≤ k ≤ N_PORTS drives `dev_sel` one-hot at bit k-1. A window read returns that port's slice `dev_rdata[32(k-1)+31 : 32(k-1)]`.
- R7: A device number above N_PORTS selects no port. Window reads return 0xFFFFFFFF and window writes leave `dev_wr` at 0.
- R8: The function field has no effect on which port or register file is selected.
- R9: A valid window write to a port raises `dev_wr` in the same cycle. In that cycle `dev_be` = (1, 3 or 0xF for sizes 1, 2, 4 bytes) shifted left by offset mod 4, and `dev_wdata` = `bus_wdata` shifted left by 8×(offset mod 4).
- R10: An access is rejected when (offset mod 4) + length exceeds 4, or when the size code is 3. A rejected write is ignored and a rejected read returns 0xFFFFFFFF.
- R11: Bus offsets 8 and above address nothing. Writes there are ignored, and reads return a value of all ones that is then aligned by R12.
- R12: A read answers with `rsp_valid` one cycle after the request. `rsp_data` is the selected 32-bit value shifted right by 8×(offset mod 4), with the bytes beyond the access length set to zero. Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | OFF_W | Byte offset of the request |
| bus_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: invalid |
| bus_wdata | input | 32 | Write data, least significant byte first |
| rsp_valid | output | 1 | Read answer valid |
| rsp_data | output | 32 | Read answer, aligned to bit 0 |
| dev_sel | output | N_PORTS | One-hot downstream port select |
| dev_idx | output | 6 | Dword register index for the ports |
| dev_wr | output | 1 | Write strobe to the selected port |
| dev_be | output | 4 | Byte enables for the write |
| dev_wdata | output | 32 | Lane-aligned write data |
| dev_rdata | input | 32*N_PORTS | Read data from every port, port 0 lowest |

## Verification
The assertions assume a few things about the inputs. Reset is low at time zero. Bus inputs are known, and each request is taken as a single-cycle pulse. Downstream read data is only needed while a port is selected. The stimulus meets these assumptions by driving every input on the falling clock edge, from one task at a time. It deasserts `bus_valid` between requests and gives each port a fixed read value that depends only on the port number and `dev_idx`. The port-routing and rejection checks use only legal size codes, with one exception: the size-3 case is sent on purpose as a read.

// File: rtl/cfgp_pkg.sv
// Shared types and helpers for the configuration access port.
// Assumes 32-bit registers and little-endian byte lanes.
package cfgp_pkg;

    // Address register layout, most significant field first.
    typedef struct packed {
        logic       en;
        logic [6:0] rsv;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] reg_idx;
        logic [1:0] lo;
    } cfg_addr_t;

    // Number of bytes a size code moves; 0 for the invalid code.
    function automatic logic [2:0] size_len(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Byte-lane mask of a size code, before lane shifting.
    function automatic logic [3:0] len_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            2'd2:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    // True when the access stays inside one 4-byte register.
    function automatic logic access_ok(input logic [1:0] lane, input logic [1:0] sz);
        return (sz != 2'd3) && (({1'b0, lane} + size_len(sz)) <= 3'd4);
    endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
// Address register with per-byte write enables.
// Assumes write data is already placed on its byte lanes.
module cfgp_addr_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] q
);
    for (genvar b = 0; b < 4; b++) begin : g_byte
        // Update one byte lane when written; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[8*b +: 8] <= 8'h00;
            else if (wr_en && be[b])
                q[8*b +: 8] <= wdata[8*b +: 8];
        end
    end
endmodule

// File: rtl/cfgp_bridge_regs.sv
// Internal configuration register file of the bridge (device 0).
// Holds fixed identity words and a small block of writable scratch dwords.
// Assumes SCR_BASE + SCRATCH_DW stays below 64.
module cfgp_bridge_regs #(
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'h7A11,
    parameter int          SCRATCH_DW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  reg_idx,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int SCR_BASE = 4;
    localparam int IW       = (SCRATCH_DW > 1) ? $clog2(SCRATCH_DW) : 1;
    localparam logic [7:0] CLASS_BRIDGE = 8'h06;
    localparam logic [7:0] SUB_HOST     = 8'h00;
    localparam logic [7:0] HDR_BRIDGE   = 8'h01;

    logic [31:0] scr [SCRATCH_DW];
    logic        in_scr;
    logic [5:0]  slot;

    assign in_scr = (reg_idx >= 6'(SCR_BASE)) && (reg_idx < 6'(SCR_BASE + SCRATCH_DW));
    assign slot   = reg_idx - 6'(SCR_BASE);

    // Byte-merged writes into the scratch dwords.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SCRATCH_DW; i++) scr[i] <= '0;
        end else if (wr_en && in_scr) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) scr[slot[IW-1:0]][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // Read mux over identity words and scratch storage.
    always_comb begin
        if (in_scr)
            rdata = scr[slot[IW-1:0]];
        else begin
            case (reg_idx)
                6'd0:    rdata = {DEVICE_ID, VENDOR_ID};
                6'd2:    rdata = {CLASS_BRIDGE, SUB_HOST, 16'h0000};
                6'd3:    rdata = {8'h00, HDR_BRIDGE, 16'h0000};
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfgp_router.sv
// Decodes the address register into a routing target.
// Only bus 0 is served; device 0 is the bridge, device k is port k-1.
// The function field is deliberately not used.
module cfgp_router
    import cfgp_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  cfg_addr_t          addr,
    output logic               tgt_bridge,
    output logic [N_PORTS-1:0] port_sel
);
    logic live;
    logic unused_fields;

    assign live          = addr.en && (addr.bus == 8'h00);
    assign tgt_bridge    = live && (addr.dev == 5'd0);
    assign unused_fields = ^{addr.rsv, addr.fn, addr.lo};

    for (genvar k = 0; k < N_PORTS; k++) begin : g_sel
        assign port_sel[k] = live && (addr.dev == 5'(k + 1));
    end
endmodule

// File: rtl/cfgp_access_port.sv
// Configuration address/data access port.
// Offsets 0-3 reach the address register and offsets 4-7 the data window.
// Window accesses go to the bridge register file or a downstream port.
// Assumes single-cycle requests; reads answer one cycle later.
module cfgp_access_port
    import cfgp_pkg::*;
#(
    parameter int          N_PORTS    = 4,
    parameter int          OFF_W      = 4,
    parameter int          SCRATCH_DW = 4,
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'h7A11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [OFF_W-1:0]      bus_offset,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_data,
    output logic [N_PORTS-1:0]    dev_sel,
    output logic [5:0]            dev_idx,
    output logic                  dev_wr,
    output logic [3:0]            dev_be,
    output logic [31:0]           dev_wdata,
    input  logic [32*N_PORTS-1:0] dev_rdata
);
    logic [31:0]        addr_q;
    cfg_addr_t          addr_f;
    logic               tgt_bridge;
    logic [N_PORTS-1:0] port_sel;
    logic [1:0]         lane;
    logic               ok, in_addr, in_win, wr_go;
    logic [3:0]         lane_be;
    logic [31:0]        lane_wdata, br_rdata, dev_word, win_word, sel_word, keep, rd_val;

    assign addr_f     = addr_q;
    assign lane       = bus_offset[1:0];
    assign ok         = access_ok(lane, bus_size);
    assign in_addr    = bus_offset < OFF_W'(4);
    assign in_win     = (bus_offset >= OFF_W'(4)) && (bus_offset < OFF_W'(8));
    assign lane_be    = 4'(len_mask(bus_size) << lane);
    assign lane_wdata = bus_wdata << {lane, 3'b000};
    assign wr_go      = bus_valid && bus_write && ok;

    cfgp_addr_reg u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_go && in_addr),
        .be    (lane_be),
        .wdata (lane_wdata),
        .q     (addr_q)
    );

    cfgp_router #(.N_PORTS(N_PORTS)) u_route (
        .addr       (addr_f),
        .tgt_bridge (tgt_bridge),
        .port_sel   (port_sel)
    );

    cfgp_bridge_regs #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .SCRATCH_DW (SCRATCH_DW)
    ) u_bridge (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go && in_win && tgt_bridge),
        .reg_idx (addr_f.reg_idx),
        .be      (lane_be),
        .wdata   (lane_wdata),
        .rdata   (br_rdata)
    );

    // Downstream port signals; all ports share index, enables and data.
    assign dev_sel   = port_sel;
    assign dev_idx   = addr_f.reg_idx;
    assign dev_wr    = wr_go && in_win && (|port_sel);
    assign dev_be    = lane_be;
    assign dev_wdata = lane_wdata;

    // Pick the read word of the selected downstream port.
    always_comb begin
        dev_word = '0;
        for (int k = 0; k < N_PORTS; k++)
            if (port_sel[k]) dev_word |= dev_rdata[32*k +: 32];
    end

    // Choose the 32-bit value behind the request and align it.
    always_comb begin
        if (tgt_bridge)     win_word = br_rdata;
        else if (|port_sel) win_word = dev_word;
        else                win_word = '1;

        if (in_addr)     sel_word = addr_q;
        else if (in_win) sel_word = win_word;
        else             sel_word = '1;

        case (bus_size)
            2'd0:    keep = 32'h0000_00FF;
            2'd1:    keep = 32'h0000_FFFF;
            default: keep = 32'hFFFF_FFFF;
        endcase

        rd_val = ok ? ((sel_word >> {lane, 3'b000}) & keep) : 32'hFFFF_FFFF;
    end

    // Register the read answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) rsp_data <= rd_val;
        end
    end
endmodule

// File: rtl/cfgp_access_port_chk.sv
// Property checker for the configuration access port, bound to every instance.
// Assumes reset is asserted at time zero.
module cfgp_access_port_chk #(
    parameter int N_PORTS = 4,
    parameter int OFF_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [OFF_W-1:0]   bus_offset,
    input logic [1:0]         bus_size,
    input logic               rsp_valid,
    input logic [31:0]        rsp_data,
    input logic [N_PORTS-1:0] dev_sel,
    input logic               dev_wr,
    input logic [3:0]         dev_be
);
    // R1
    rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dev_sel));

    // R7
    wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n) dev_wr |-> $onehot(dev_sel));

    // R9
    wr_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (bus_valid && bus_write && dev_be != 4'b0000));

    // R10
    cross_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size == 2'd2 && bus_offset[1:0] != 2'b00) |-> !dev_wr);

    // R11
    far_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size == 2'd2 && bus_offset >= OFF_W'(8))
        |=> (rsp_data == 32'hFFFF_FFFF));

    // R12
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && !bus_write));
endmodule

bind cfgp_access_port cfgp_access_port_chk #(.N_PORTS(N_PORTS), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_offset (bus_offset),
    .bus_size   (bus_size),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .dev_sel    (dev_sel),
    .dev_wr     (dev_wr),
    .dev_be     (dev_be)
);

// File: tb/tb_cfgp_access_port.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected answers, a monitor pops them.
module tb_cfgp_access_port;
    localparam int N  = 4;
    localparam int OW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [OW-1:0]   bus_offset = '0;
    logic [1:0]      bus_size = 2'd2;
    logic [31:0]     bus_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_data;
    logic [N-1:0]    dev_sel;
    logic [5:0]      dev_idx;
    logic            dev_wr;
    logic [3:0]      dev_be;
    logic [31:0]     dev_wdata;
    logic [32*N-1:0] dev_rdata;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    cfgp_access_port #(.N_PORTS(N), .OFF_W(OW)) dut (.*);

    // Fixed port read value depending on port number and register index.
    function automatic logic [31:0] port_val(input int k, input logic [5:0] idx);
        return 32'hD000_005A | (32'(k) << 16) | (32'(idx) << 8);
    endfunction

    always_comb begin
        for (int k = 0; k < N; k++) dev_rdata[32*k +: 32] = port_val(k, dev_idx);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each read answer against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (exp_q.size() == 0) check("R12 unexpected answer", 32'd1, 32'd0);
                else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [OW-1:0] off, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_offset = off; bus_size = sz; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Window write that also checks the downstream strobe in the same cycle.
    task automatic wr_chk(input logic [OW-1:0] off, input logic [1:0] sz, input logic [31:0] d,
                          input logic ew, input logic [3:0] eb, input logic [31:0] ed, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_offset = off; bus_size = sz; bus_wdata = d;
        #1;
        check(req, 32'(dev_wr), 32'(ew));
        if (ew) begin
            check(req, 32'(dev_be), 32'(eb));
            check(req, dev_wdata, ed);
        end
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_read(input logic [OW-1:0] off, input logic [1:0] sz,
                           input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_offset = off; bus_size = sz;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        do_write(0, 2'd2, a);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 dev_sel", 32'(dev_sel), 0);
        do_read(0, 2'd2, 32'h0000_0000, "R1 addr reg reset");
        do_read(4, 2'd2, 32'hFFFF_FFFF, "R1 window disabled");

        // R2: device 2, index 5
        set_addr(32'h8000_1014);
        do_read(0, 2'd2, 32'h8000_1014, "R2 addr readback");
        check("R2 dev_sel", 32'(dev_sel), 32'b0010);
        check("R2 dev_idx", 32'(dev_idx), 5);

        // R3: byte and halfword merges
        do_write(2, 2'd0, 32'h0000_0033);
        do_read(0, 2'd2, 32'h8033_1014, "R3 byte merge");
        check("R4 nonzero bus deselects", 32'(dev_sel), 0);
        do_read(4, 2'd2, 32'hFFFF_FFFF, "R4 bus nonzero");
        do_write(2, 2'd1, 32'h0000_8000);
        do_read(0, 2'd2, 32'h8000_1014, "R3 halfword merge");
        do_read(1, 2'd1, 32'h0000_0010, "R12 halfword at lane 1");

        // R6 / R12: port 1 reads
        do_read(4, 2'd2, 32'hD001_055A, "R6 port read");
        do_read(6, 2'd0, 32'h0000_0001, "R12 byte at lane 2");

        // R9: halfword write at lane 1
        wr_chk(5, 2'd1, 32'h0000_BEEF, 1'b1, 4'b0110, 32'h00BE_EF00, "R9 lanes");

        // R8: function 7 routes the same
        set_addr(32'h8000_1714);
        check("R8 function ignored", 32'(dev_sel), 32'b0010);
        do_read(4, 2'd2, 32'hD001_055A, "R8 function ignored read");

        // R7: device 5 absent
        set_addr(32'h8000_2814);
        check("R7 no select", 32'(dev_sel), 0);
        do_read(4, 2'd2, 32'hFFFF_FFFF, "R7 absent read");
        wr_chk(4, 2'd2, 32'h1234_5678, 1'b0, 4'b0, 32'h0, "R7 absent write");
        set_addr(32'h8000_2014);
        check("R6 last port select", 32'(dev_sel), 32'b1000);
        do_read(4, 2'd2, 32'hD003_055A, "R6 last port read");

        // R5: bridge register file
        set_addr(32'h8000_0000);
        do_read(4, 2'd2, 32'h7A11_C0DE, "R5 ids");
        set_addr(32'h8000_0008);
        do_read(4, 2'd2, 32'h0600_0000, "R5 class");
        set_addr(32'h8000_000C);
        do_read(4, 2'd2, 32'h0001_0000, "R5 header type");
        set_addr(32'h8000_0010);
        wr_chk(4, 2'd2, 32'h1122_3344, 1'b0, 4'b0, 32'h0, "R5 bridge write no strobe");
        do_write(7, 2'd0, 32'h0000_00AA);
        do_read(4, 2'd2, 32'hAA22_3344, "R5 scratch merge");
        set_addr(32'h8000_0004);
        do_write(4, 2'd2, 32'hFFFF_FFFF);
        do_read(4, 2'd2, 32'h0000_0000, "R5 read-only dword");

        // R10: boundary crossing and invalid size
        set_addr(32'h8000_0010);
        do_write(6, 2'd2, 32'h0000_0000);
        do_read(4, 2'd2, 32'hAA22_3344, "R10 crossing write ignored");
        do_read(5, 2'd2, 32'hFFFF_FFFF, "R10 crossing read");
        do_write(3, 2'd1, 32'h0000_FFFF);
        do_read(0, 2'd2, 32'h8000_0010, "R10 crossing addr write ignored");
        do_read(4, 2'd3, 32'hFFFF_FFFF, "R10 size code 3");

        // R11: offsets beyond the window
        do_write(8, 2'd2, 32'h0000_0000);
        do_read(0, 2'd2, 32'h8000_0010, "R11 far write ignored");
        do_read(8, 2'd2, 32'hFFFF_FFFF, "R11 far read");
        do_read(12, 2'd0, 32'h0000_00FF, "R11 far byte read");

        // R4: bus nonzero on device 0, then enable clear
        set_addr(32'h8001_0000);
        do_read(4, 2'd2, 32'hFFFF_FFFF, "R4 bus 1 bridge");
        set_addr(32'h0000_0000);
        do_read(4, 2'd2, 32'hFFFF_FFFF, "R4 enable clear");

        repeat (3) @(negedge clk);
        check("R12 queue drained", 32'(exp_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(200000 * 5);
        n_checks++; n_errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule